// File: doc/BRIEF.md
# Multi-Channel Timestamp Capture with Ordered Sequence Buffer

This block takes a timer count from outside and copies it into capture slots when channel inputs change. Each channel has its own input pin and a two-bit trigger field. The field selects rising-edge capture, falling-edge capture, or no capture. In normal operation, channel i always writes slot i and raises a one-cycle interrupt pulse on its own line. A single-shot option keeps only the first value a channel captures. The lock is released when the capture enable is dropped. An internal event strobe can also request a capture. It names its target channel through an index port, and the index must fall inside the configured channel count.

In sequential operation the slots become an ordered buffer. Every accepted capture, from any channel or from the event strobe, goes into the next free slot, together with the index of its source channel. The per-channel interrupts stay quiet in this operation. A single done pulse fires when the configured number of captures has been stored. The slot index then returns to zero, and the stored entries stay readable until new captures overwrite them. Captures happen only while the capture enable and the periodic-mode flag are both high. The counter itself is produced elsewhere and is never touched.

Top module: `cap_seq_unit`

## Requirements
- R1: Trigger field bits [2i+1:2i] of `trig_cfg` set channel i: 01 captures on a rising edge, 10 captures on a falling edge, 00 and 11 disable the channel. In normal operation a qualifying edge stores `count_in` into slot i and pulses `ch_irq[i]` high for exactly one cycle.
- R2: A channel input passes two synchroniser flops and one edge flop. If an input changes before clock edge k, the slot write and the `ch_irq` pulse appear after edge k+2. `rd_data` and `rd_src` show the slot addressed by `rd_addr` one clock edge after the address is applied.
- R3: With `single_mode` high, a channel accepts only its first capture, and later edges leave its slot and interrupt unchanged. Driving `cap_en` low clears every lock.
- R4: While `cap_en` is low, no edge and no event writes a slot or raises an interrupt.
- R5: While `periodic_mode` is low, no edge and no event writes a slot or raises an interrupt.
- R6: An `evt_in` pulse captures `count_in` for channel `evt_ch` on the next clock edge, but only when `evt_ch` is below `active_ch`. Channels whose index is at or above `active_ch` never capture.
- R7: With `seq_mode` high, accepted captures fill slots 0, 1, 2 and so on in arrival order. `rd_src` returns the source channel of each slot, and `ch_irq` stays low.
- R8: In sequential operation `seq_done` pulses for one cycle in the cycle after the capture that fills the last position of the sequence. The slot index then returns to zero, and entries that are not overwritten keep their values. A `seq_len` of 0 acts as 1, and a value above the channel count acts as the channel count.
- R9: Captures that arrive in the same cycle are placed lowest channel first. Captures beyond the end of the sequence in that cycle are dropped.
- R10: After reset all slots, sources, `ch_irq` and `seq_done` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_in | input | CNT_W | Timer count to snapshot |
| ch_in | input | NUM_CH | Asynchronous channel inputs |
| trig_cfg | input | 2*NUM_CH | Per-channel trigger field |
| active_ch | input | IDX_W+1 | Number of configured channels |
| cap_en | input | 1 | Capture enable |
| periodic_mode | input | 1 | High while the timer runs periodically |
| single_mode | input | 1 | Keep first capture per channel |
| seq_mode | input | 1 | Ordered sequence operation |
| seq_len | input | IDX_W+1 | Captures per sequence |
| evt_in | input | 1 | Synchronous event capture strobe |
| evt_ch | input | IDX_W | Target channel of the event |
| rd_addr | input | IDX_W | Slot to read |
| rd_data | output | CNT_W | Captured count of the addressed slot |
| rd_src | output | IDX_W | Source channel of the addressed slot |
| ch_irq | output | NUM_CH | Per-channel capture pulses |
| seq_done | output | 1 | Sequence complete pulse |

## Verification
The bench aims at the ordering corner cases. It raises two channels in the same cycle, where a design that ignored channel priority would swap their sources in the buffer. It also ends a sequence with two captures in one cycle, where a design that failed to drop the surplus would corrupt a slot or carry a stale index into the next sequence. Single-shot locking is checked both while the lock is held and after it is released, which catches a lock that never clears. Captures are also attempted with the enable low, with the periodic flag low, with an out-of-range event index and on a channel beyond the configured count. A missing gate would show up there as an overwritten slot or a stray interrupt. The exact three-edge latency is sampled cycle by cycle, so an extra or missing synchroniser stage is caught.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RSVD = 2'b11
  } trig_e;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
  import cap_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     ch_in,
  input  logic [2*NUM_CH-1:0]   trig_cfg,
  output logic [NUM_CH-1:0]     hit
);
  localparam int MSB = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    trig_e                  mode;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], ch_in[g]};
        prev_q <= sync_q[MSB];
      end
    end

    assign mode   = trig_e'(trig_cfg[2*g +: 2]);
    assign hit[g] = ((mode == TRIG_RISE) &  sync_q[MSB] & ~prev_q) |
                    ((mode == TRIG_FALL) & ~sync_q[MSB] &  prev_q);
  end
endmodule

// File: rtl/cap_seq_alloc.sv
module cap_seq_alloc #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  seq_mode,
  input  logic [LEN_W-1:0]      seq_len,
  input  logic [NUM_CH-1:0]     req,
  output logic [NUM_CH-1:0]     wr_en,
  output logic [IDX_W-1:0]      wr_src [NUM_CH],
  output logic [NUM_CH-1:0]     grant,
  output logic                  seq_done
);
  logic [LEN_W-1:0] seq_idx;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] pos;
  logic             done_c;

  always_comb begin
    if (seq_len == '0)                      eff_len = LEN_W'(1);
    else if (seq_len > LEN_W'(NUM_CH))      eff_len = LEN_W'(NUM_CH);
    else                                    eff_len = seq_len;
  end

  // Slot allocation: lowest channel is placed first, overflow is dropped.
  always_comb begin
    wr_en  = '0;
    grant  = '0;
    done_c = 1'b0;
    pos    = seq_idx;
    for (int s = 0; s < NUM_CH; s++) wr_src[s] = '0;
    if (!seq_mode) begin
      wr_en = req;
      grant = req;
      for (int s = 0; s < NUM_CH; s++) wr_src[s] = IDX_W'(s);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (req[c] && (pos < eff_len)) begin
          wr_en[pos[IDX_W-1:0]]  = 1'b1;
          wr_src[pos[IDX_W-1:0]] = IDX_W'(c);
          grant[c]               = 1'b1;
          pos                    = pos + LEN_W'(1);
        end
      end
      done_c = (grant != '0) && (pos == eff_len);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_idx  <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= done_c;
      if (!seq_mode || done_c) seq_idx <= '0;
      else                     seq_idx <= pos;
    end
  end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  wr_en,
  input  logic [IDX_W-1:0]   wr_src [NUM_CH],
  input  logic [CNT_W-1:0]   count_in,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic [IDX_W-1:0]   rd_src
);
  logic [CNT_W-1:0] val_q [NUM_CH];
  logic [IDX_W-1:0] src_q [NUM_CH];

  for (genvar s = 0; s < NUM_CH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[s] <= '0;
        src_q[s] <= '0;
      end else if (wr_en[s]) begin
        val_q[s] <= count_in;
        src_q[s] <= wr_src[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_src  <= '0;
    end else begin
      rd_data <= val_q[rd_addr];
      rd_src  <= src_q[rd_addr];
    end
  end
endmodule

// File: rtl/cap_seq_unit.sv
module cap_seq_unit #(
  parameter int CNT_W       = 32,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     count_in,
  input  logic [NUM_CH-1:0]    ch_in,
  input  logic [2*NUM_CH-1:0]  trig_cfg,
  input  logic [LEN_W-1:0]     active_ch,
  input  logic                 cap_en,
  input  logic                 periodic_mode,
  input  logic                 single_mode,
  input  logic                 seq_mode,
  input  logic [LEN_W-1:0]     seq_len,
  input  logic                 evt_in,
  input  logic [IDX_W-1:0]     evt_ch,
  input  logic [IDX_W-1:0]     rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic [IDX_W-1:0]     rd_src,
  output logic [NUM_CH-1:0]    ch_irq,
  output logic                 seq_done
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] act_mask;
  logic [NUM_CH-1:0] evt_vec;
  logic [NUM_CH-1:0] lock_q;
  logic [NUM_CH-1:0] req;
  logic [NUM_CH-1:0] wr_en;
  logic [NUM_CH-1:0] grant;
  logic [IDX_W-1:0]  wr_src [NUM_CH];

  cap_edge_detect #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .ch_in(ch_in), .trig_cfg(trig_cfg), .hit(hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_act
    assign act_mask[g] = (LEN_W'(g) < active_ch);
  end

  assign evt_vec = (evt_in && (LEN_W'(evt_ch) < active_ch)) ?
                   (NUM_CH'(1) << evt_ch) : '0;

  always_comb begin
    req = '0;
    if (cap_en && periodic_mode)
      req = (hit | evt_vec) & act_mask & ~(single_mode ? lock_q : '0);
  end

  cap_seq_alloc #(.NUM_CH(NUM_CH)) u_alloc (
    .clk(clk), .rst(rst), .seq_mode(seq_mode), .seq_len(seq_len), .req(req),
    .wr_en(wr_en), .wr_src(wr_src), .grant(grant), .seq_done(seq_done)
  );

  cap_store #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_src(wr_src), .count_in(count_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_src(rd_src)
  );

  always_ff @(posedge clk) begin
    if (rst || !cap_en) lock_q <= '0;
    else if (single_mode) lock_q <= lock_q | grant;
    else lock_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)           ch_irq <= '0;
    else if (seq_mode) ch_irq <= '0;
    else               ch_irq <= grant;
  end
endmodule

// File: rtl/cap_seq_unit_chk.sv
module cap_seq_unit_chk #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int LEN_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_en,
  input logic              periodic_mode,
  input logic              seq_mode,
  input logic [LEN_W-1:0]  active_ch,
  input logic [NUM_CH-1:0] ch_irq,
  input logic              seq_done
);
  logic [NUM_CH-1:0] allowed;
  always_comb
    for (int i = 0; i < NUM_CH; i++) allowed[i] = (LEN_W'(i) < active_ch);

  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_irq != '0) |-> $past(cap_en));

  assert_irq_needs_periodic_R5: assert property (@(posedge clk) disable iff (rst)
    (ch_irq != '0) |-> $past(periodic_mode));

  assert_irq_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (ch_irq & ~$past(allowed)) == '0);

  assert_seq_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $past(seq_mode) |-> (ch_irq == '0));

  assert_done_from_seq_R8: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> $past(seq_mode && cap_en && periodic_mode));
endmodule

bind cap_seq_unit cap_seq_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .cap_en(cap_en), .periodic_mode(periodic_mode),
  .seq_mode(seq_mode), .active_ch(active_ch), .ch_irq(ch_irq), .seq_done(seq_done)
);

// File: tb/tb_cap_seq_unit.sv
module tb_cap_seq_unit;
  localparam int CNT_W = 32, NUM_CH = 8, IDX_W = 3, LEN_W = 4;

  logic clk = 0, rst = 1;
  logic [CNT_W-1:0]    count_in = '0;
  logic [NUM_CH-1:0]   ch_in = '0;
  logic [2*NUM_CH-1:0] trig_cfg = '0;
  logic [LEN_W-1:0]    active_ch = 4'd8;
  logic cap_en = 0, periodic_mode = 1, single_mode = 0, seq_mode = 0, evt_in = 0;
  logic [LEN_W-1:0]    seq_len = 4'd1;
  logic [IDX_W-1:0]    evt_ch = '0, rd_addr = '0;
  logic [CNT_W-1:0]    rd_data;
  logic [IDX_W-1:0]    rd_src;
  logic [NUM_CH-1:0]   ch_irq;
  logic                seq_done;

  cap_seq_unit #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) dut (
    .clk(clk), .rst(rst), .count_in(count_in), .ch_in(ch_in), .trig_cfg(trig_cfg),
    .active_ch(active_ch), .cap_en(cap_en), .periodic_mode(periodic_mode),
    .single_mode(single_mode), .seq_mode(seq_mode), .seq_len(seq_len),
    .evt_in(evt_in), .evt_ch(evt_ch), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_src(rd_src), .ch_irq(ch_irq), .seq_done(seq_done)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int irq_cnt [NUM_CH] = '{default: 0};
  int done_cnt = 0;

  always @(negedge clk) begin
    for (int i = 0; i < NUM_CH; i++) if (ch_irq[i]) irq_cnt[i] = irq_cnt[i] + 1;
    if (seq_done) done_cnt = done_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_slot(input int a, output logic [CNT_W-1:0] v, output logic [IDX_W-1:0] s);
    rd_addr = IDX_W'(a);
    cyc(2);
    v = rd_data;
    s = rd_src;
  endtask

  task automatic set_trig(input int ch, input logic [1:0] code);
    trig_cfg[2*ch +: 2] = code;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Vector fields: ch[22:20] trig[19:18] rise[17] exp[16] cnt[15:0]
  localparam int VN = 8;
  localparam logic [22:0] VEC [VN] = '{
    {3'd0, 2'b01, 1'b1, 1'b1, 16'h1111},
    {3'd0, 2'b01, 1'b0, 1'b0, 16'h2222},
    {3'd1, 2'b10, 1'b0, 1'b1, 16'h3333},
    {3'd1, 2'b10, 1'b1, 1'b0, 16'h4444},
    {3'd2, 2'b00, 1'b1, 1'b0, 16'h5555},
    {3'd3, 2'b11, 1'b1, 1'b0, 16'h6666},
    {3'd7, 2'b10, 1'b0, 1'b1, 16'h7777},
    {3'd6, 2'b01, 1'b1, 1'b1, 16'h8888}
  };

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] v;
    logic [IDX_W-1:0] s;
    logic [CNT_W-1:0] model [NUM_CH];
    int base, dbase;
    for (int i = 0; i < NUM_CH; i++) model[i] = '0;

    cyc(4);
    rst = 0;
    cyc(1);
    // R10 reset state
    check(ch_irq == '0, "R10 irq", ch_irq, 0);
    check(seq_done == 1'b0, "R10 done", seq_done, 0);
    read_slot(0, v, s);
    check(v == '0 && s == '0, "R10 slot", v, 0);

    // R1 trigger field vectors
    for (int k = 0; k < VN; k++) begin
      int ch;
      ch = int'(VEC[k][22:20]);
      cap_en = 0;
      trig_cfg = '0;
      set_trig(ch, VEC[k][19:18]);
      ch_in[ch] = ~VEC[k][17];
      cyc(5);
      cap_en = 1;
      count_in = {16'h0, VEC[k][15:0]};
      base = irq_cnt[ch];
      cyc(2);
      ch_in[ch] = VEC[k][17];
      cyc(6);
      if (VEC[k][16]) model[ch] = count_in;
      check(irq_cnt[ch] - base == int'(VEC[k][16]), "R1 irq", irq_cnt[ch] - base, VEC[k][16]);
      read_slot(ch, v, s);
      check(v == model[ch], "R1 slot", v, model[ch]);
    end

    // R2 exact latency on channel 4
    cap_en = 0; trig_cfg = '0; ch_in = '0; cyc(5);
    cap_en = 1; set_trig(4, 2'b01); count_in = 32'h4A4A; cyc(2);
    ch_in[4] = 1;
    cyc(2);
    check(ch_irq[4] == 1'b0, "R2 early", ch_irq[4], 0);
    cyc(1);
    check(ch_irq[4] == 1'b1, "R2 pulse", ch_irq[4], 1);
    cyc(1);
    check(ch_irq[4] == 1'b0, "R2 one cycle", ch_irq[4], 0);
    read_slot(4, v, s);
    check(v == 32'h4A4A, "R2 slot", v, 32'h4A4A);

    // R3 single mode lock
    single_mode = 1; set_trig(5, 2'b01); base = irq_cnt[5];
    count_in = 32'h5001; ch_in[5] = 1; cyc(5);
    ch_in[5] = 0; cyc(5);
    count_in = 32'h5002; ch_in[5] = 1; cyc(6);
    read_slot(5, v, s);
    check(v == 32'h5001, "R3 lock held", v, 32'h5001);
    check(irq_cnt[5] - base == 1, "R3 irq once", irq_cnt[5] - base, 1);
    cap_en = 0; ch_in[5] = 0; cyc(5);
    cap_en = 1; count_in = 32'h5003; ch_in[5] = 1; cyc(6);
    read_slot(5, v, s);
    check(v == 32'h5003, "R3 lock released", v, 32'h5003);
    single_mode = 0;

    // R4 enable low
    set_trig(5, 2'b10); cap_en = 0; base = irq_cnt[5];
    count_in = 32'h5004; ch_in[5] = 0; cyc(6);
    read_slot(5, v, s);
    check(v == 32'h5003 && irq_cnt[5] == base, "R4 disabled", v, 32'h5003);

    // R5 periodic low
    set_trig(5, 2'b01); cap_en = 1; periodic_mode = 0;
    count_in = 32'h5005; ch_in[5] = 1; cyc(6);
    read_slot(5, v, s);
    check(v == 32'h5003 && irq_cnt[5] == base, "R5 not periodic", v, 32'h5003);
    periodic_mode = 1; cyc(2);

    // R6 event capture and channel limit
    base = irq_cnt[3];
    count_in = 32'h3E3E; evt_ch = 3'd3; evt_in = 1; cyc(1); evt_in = 0; cyc(3);
    read_slot(3, v, s);
    check(v == 32'h3E3E && irq_cnt[3] - base == 1, "R6 event", v, 32'h3E3E);
    active_ch = 4'd3; base = irq_cnt[5]; dbase = irq_cnt[4];
    count_in = 32'h5E5E; evt_ch = 3'd5; evt_in = 1; cyc(1); evt_in = 0;
    set_trig(4, 2'b10); ch_in[4] = 0; cyc(6);
    read_slot(5, v, s);
    check(v == 32'h5003 && irq_cnt[5] == base, "R6 event out of range", v, 32'h5003);
    read_slot(4, v, s);
    check(v == 32'h4A4A && irq_cnt[4] == dbase, "R6 inactive channel", v, 32'h4A4A);

    // R7 R9 sequence with simultaneous edges
    cap_en = 0; trig_cfg = '0; ch_in = '0; active_ch = 4'd8; cyc(6);
    seq_mode = 1; seq_len = 4'd3;
    set_trig(1, 2'b01); set_trig(2, 2'b01); set_trig(4, 2'b01);
    cap_en = 1; cyc(2);
    base = irq_cnt[1] + irq_cnt[2] + irq_cnt[4]; dbase = done_cnt;
    count_in = 32'h100; ch_in[2] = 1; ch_in[1] = 1; cyc(6);
    count_in = 32'h200; ch_in[4] = 1; cyc(6);
    read_slot(0, v, s);
    check(v == 32'h100 && s == 3'd1, "R9 lower first", s, 1);
    read_slot(1, v, s);
    check(v == 32'h100 && s == 3'd2, "R7 slot1", s, 2);
    read_slot(2, v, s);
    check(v == 32'h200 && s == 3'd4, "R7 slot2", v, 32'h200);
    check(irq_cnt[1] + irq_cnt[2] + irq_cnt[4] == base, "R7 no irq",
          irq_cnt[1] + irq_cnt[2] + irq_cnt[4] - base, 0);
    check(done_cnt - dbase == 1, "R8 done once", done_cnt - dbase, 1);

    // R8 index restarts, untouched entries kept
    count_in = 32'h300; evt_ch = 3'd6; evt_in = 1; cyc(1); evt_in = 0; cyc(3);
    read_slot(0, v, s);
    check(v == 32'h300 && s == 3'd6, "R8 restart slot0", v, 32'h300);
    read_slot(1, v, s);
    check(v == 32'h100 && s == 3'd2, "R8 slot1 kept", v, 32'h100);

    // R9 overflow in completing cycle is dropped (index is 1, length 2)
    seq_len = 4'd2; set_trig(1, 2'b10); set_trig(4, 2'b10); dbase = done_cnt;
    count_in = 32'h400; ch_in[4] = 0; ch_in[1] = 0; cyc(6);
    read_slot(1, v, s);
    check(v == 32'h400 && s == 3'd1, "R9 last slot", v, 32'h400);
    read_slot(2, v, s);
    check(v == 32'h200 && s == 3'd4, "R9 surplus dropped", v, 32'h200);
    check(done_cnt - dbase == 1, "R9 done", done_cnt - dbase, 1);

    // R8 zero length acts as one
    seq_len = 4'd0; set_trig(2, 2'b10); dbase = done_cnt;
    count_in = 32'h500; ch_in[2] = 0; cyc(6);
    read_slot(0, v, s);
    check(v == 32'h500 && s == 3'd2, "R8 len0 slot", v, 32'h500);
    check(done_cnt - dbase == 1, "R8 len0 done", done_cnt - dbase, 1);

    report();
    $finish;
  end
endmodule